// File: doc/BRIEF.md
# Single-Wire Identity Responder

This block is the slave end of a single-wire, open-drain bus for a device whose only content is a 64-bit identity code. It watches the sampled level of the shared line and measures every low period against a microsecond tick. A long low period is a bus reset, and the block answers it with a presence pulse of its own. After the presence pulse it takes in one 8-bit command from the master, one bit per time slot. It then either streams its identity code back or joins a bitwise search in which the master walks the identity tree one bit at a time.

The block never drives the line high. It has one pull-low enable, which the pad turns into an open-drain pulldown, and a few status flags that show its current phase. The identity is built at elaboration from a family byte and a 48-bit serial number, with the check byte computed from them. Any low period long enough to count as a reset cancels whatever the block is doing.

Top module: `owid_responder`

## Requirements
- R1: A low period of at least RESET_MIN_US ticks (default 480), followed by the line going high, is a bus reset and always leads to a presence pulse.
- R2: The presence pulse begins between 15 and 60 µs after the line goes high at the end of the reset, and it holds the line low for between 60 and 240 µs.
- R3: A low period shorter than RESET_MIN_US (for example 300 µs) never produces a presence pulse.
- R4: After the presence pulse the block takes 8 command bits, least significant first, one per slot. Each bit is the line level SAMPLE_US (30) ticks after the slot's falling edge, so a 25 µs low reads as 1 and a 40 µs low reads as 0.
- R5: Command 33h makes the block send the 64 identity bits in 64 read slots, bit 0 first. For a 0 it pulls the line low from the falling edge for HOLD_US (30) ticks; for a 1 it does not pull low at all.
- R6: Identity layout: bits 7:0 hold the family code (default 01h), bits 55:8 hold the serial number, and bits 63:56 hold a check byte. The check byte uses polynomial x^8+x^5+x^4+1 with a zero start value, fed least significant bit first, so the check register ends at zero after all 64 bits.
- R7: Command F0h starts a search. For each identity bit, from bit 0 upward, the block sends the bit in the first slot and its complement in the second, then reads the master's choice in the third. On a match it moves on to the next bit.
- R8: In a search, a third-slot bit that differs from the identity bit takes the block out of the search. It drives nothing more until the next reset, and muted_o goes high.
- R9: Any command other than 33h and F0h (55h and CCh included) makes the block silent until the next reset: no pull-low in any slot, and muted_o high.
- R10: A reset low period arriving in any phase, in the middle of a transfer included, cancels that transfer. The reset is answered with presence, and a fresh command is accepted after it.
- R11: presence_o is high while the presence pulse is driven, sending_o during the identity transfer, searching_o during a search, and muted_o once the block is silent. At most one of these is high at a time.
- R12: After rst, drive_low_o and all status flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle strobe each microsecond |
| line_i | input | 1 | Synchronised level of the shared line |
| drive_low_o | output | 1 | Pull the line low when high |
| presence_o | output | 1 | Presence pulse being driven |
| sending_o | output | 1 | Identity transfer phase |
| searching_o | output | 1 | Search phase |
| muted_o | output | 1 | Silent until next bus reset |

## Verification
The assertions assume that line_i is already synchronous to clk and that it equals the wired-AND of the master's drive and drive_low_o. They also assume the master begins a slot only after the line has been high since the previous one, and that slots last well beyond SAMPLE_US and HOLD_US. The bench builds the bus as exactly that wired-AND. Its master tasks change levels only on the falling clock edge, use 80 µs slots with lows of 3 to 70 µs, and leave 300 µs of idle line after each reset, so every slot closes before the next falling edge.

// File: rtl/owid_pkg.sv
package owid_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRES,
        ST_CMD,
        ST_ROM,
        ST_SRCH,
        ST_MUTE
    } owid_state_e;

    typedef enum logic [1:0] {
        TRI_TRUE,
        TRI_COMP,
        TRI_PICK
    } tri_phase_e;

    typedef struct packed {
        logic fall;
        logic reset_done;
        logic long_low;
    } line_evt_t;

    typedef struct packed {
        logic active;
        logic hold;
        logic bit_v;
        logic done;
    } slot_stat_t;

    localparam logic [7:0] CMD_READ_ID   = 8'h33;
    localparam logic [7:0] CMD_SEARCH_ID = 8'hF0;
    localparam int         ID_W          = 64;

    function automatic logic [7:0] chk_step(input logic [7:0] c, input logic b);
        logic       fb;
        logic [7:0] n;
        fb = c[0] ^ b;
        n  = c >> 1;
        if (fb) n = n ^ 8'h8C;
        return n;
    endfunction

    function automatic logic [ID_W-1:0] make_id(input logic [7:0] fam, input logic [47:0] ser);
        logic [55:0] body;
        logic [7:0]  c;
        body = {ser, fam};
        c    = 8'h00;
        for (int i = 0; i < 56; i++) c = chk_step(c, body[i]);
        return {c, body};
    endfunction

endpackage

// File: rtl/owid_line_mon.sv
module owid_line_mon #(
    parameter int RESET_MIN_US = 480
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_us,
    input  logic                line_i,
    output owid_pkg::line_evt_t evt_o
);
    localparam int            CW  = $clog2(RESET_MIN_US + 1);
    localparam logic [CW-1:0] LIM = CW'(RESET_MIN_US);

    logic          line_q;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= 1'b1;
            low_cnt <= '0;
        end else begin
            line_q <= line_i;
            if (line_i)
                low_cnt <= '0;
            else if (tick_us && low_cnt != LIM)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    always_comb begin
        evt_o.fall       = line_q & ~line_i;
        evt_o.reset_done = ~line_q & line_i & (low_cnt == LIM);
        evt_o.long_low   = ~line_i & (low_cnt == LIM);
    end

    // R1: a reset is recognised only at the end of a low period
    p_reset_ends_low_r1: assert property (@(posedge clk) disable iff (rst)
        evt_o.reset_done |-> $past(!line_i));

endmodule

// File: rtl/owid_presence.sv
module owid_presence #(
    parameter int WAIT_US = 30,
    parameter int LEN_US  = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_us,
    input  logic start_i,
    input  logic abort_i,
    output logic drive_o,
    output logic done_o
);
    localparam int            MAXV = (WAIT_US > LEN_US) ? WAIT_US : LEN_US;
    localparam int            CW   = $clog2(MAXV + 1);
    localparam logic [CW-1:0] W_LAST = CW'(WAIT_US - 1);
    localparam logic [CW-1:0] L_LAST = CW'(LEN_US - 1);

    typedef enum logic [1:0] {P_IDLE, P_WAIT, P_DRIVE} pres_e;

    pres_e         st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        done_o <= 1'b0;
        if (rst || abort_i) begin
            st  <= P_IDLE;
            cnt <= '0;
        end else if (start_i) begin
            st  <= P_WAIT;
            cnt <= '0;
        end else if (tick_us) begin
            unique case (st)
                P_WAIT: begin
                    if (cnt == W_LAST) begin
                        st  <= P_DRIVE;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                P_DRIVE: begin
                    if (cnt == L_LAST) begin
                        st     <= P_IDLE;
                        cnt    <= '0;
                        done_o <= 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign drive_o = (st == P_DRIVE);

    // R2: the line is always released for a wait time after a reset ends
    p_wait_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !drive_o);

endmodule

// File: rtl/owid_slot_timer.sv
module owid_slot_timer #(
    parameter int SAMPLE_US = 30,
    parameter int HOLD_US   = 30
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_us,
    input  logic                 en_i,
    input  logic                 fall_i,
    input  logic                 line_i,
    output owid_pkg::slot_stat_t stat_o
);
    localparam int            END_US = (SAMPLE_US > HOLD_US) ? SAMPLE_US : HOLD_US;
    localparam int            EW     = $clog2(END_US + 1);
    localparam logic [EW-1:0] END_V  = EW'(END_US);
    localparam logic [EW-1:0] SMP_PRE = EW'(SAMPLE_US - 1);
    localparam logic [EW-1:0] HOLD_V = EW'(HOLD_US);

    logic          act;
    logic          smp;
    logic [EW-1:0] el;
    logic          done;

    assign done = act && (el == END_V) && line_i;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            act <= 1'b0;
            el  <= '0;
            smp <= 1'b1;
        end else if (!act) begin
            if (fall_i) begin
                act <= 1'b1;
                el  <= '0;
            end
        end else begin
            if (tick_us && el != END_V) el <= el + 1'b1;
            if (tick_us && el == SMP_PRE) smp <= line_i;
            if (done) act <= 1'b0;
        end
    end

    always_comb begin
        stat_o.active = act;
        stat_o.hold   = act && (el < HOLD_V);
        stat_o.bit_v  = smp;
        stat_o.done   = done;
    end

    // R4: a slot closes only after its sample point has passed
    p_close_after_sample_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(act) && $past(en_i) |-> $past(el) == END_V);

endmodule

// File: rtl/owid_responder.sv
module owid_responder #(
    parameter logic [7:0]  FAMILY_CODE  = 8'h01,
    parameter logic [47:0] SERIAL_NO    = 48'h3C5A96E10F27,
    parameter int          RESET_MIN_US = 480,
    parameter int          PRES_WAIT_US = 30,
    parameter int          PRES_LEN_US  = 120,
    parameter int          SAMPLE_US    = 30,
    parameter int          HOLD_US      = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_us,
    input  logic line_i,
    output logic drive_low_o,
    output logic presence_o,
    output logic sending_o,
    output logic searching_o,
    output logic muted_o
);
    import owid_pkg::*;

    localparam logic [ID_W-1:0] ID   = make_id(FAMILY_CODE, SERIAL_NO);
    localparam int              IW   = $clog2(ID_W);
    localparam logic [IW-1:0]   LAST = IW'(ID_W - 1);

    line_evt_t   evt;
    slot_stat_t  slot;
    owid_state_e state;
    tri_phase_e  tri_ph;
    logic [7:0]  cmd_sr;
    logic [2:0]  cmd_cnt;
    logic [IW-1:0] bit_idx;
    logic        pres_drive, pres_done;
    logic        slot_en, slot_drive, id_bit;
    logic [7:0]  cmd_next;

    owid_line_mon #(.RESET_MIN_US(RESET_MIN_US)) mon_i (
        .clk(clk), .rst(rst), .tick_us(tick_us), .line_i(line_i), .evt_o(evt)
    );

    owid_presence #(.WAIT_US(PRES_WAIT_US), .LEN_US(PRES_LEN_US)) pres_i (
        .clk(clk), .rst(rst), .tick_us(tick_us),
        .start_i(evt.reset_done), .abort_i(evt.long_low),
        .drive_o(pres_drive), .done_o(pres_done)
    );

    assign slot_en = (state == ST_CMD) || (state == ST_ROM) || (state == ST_SRCH);

    owid_slot_timer #(.SAMPLE_US(SAMPLE_US), .HOLD_US(HOLD_US)) slot_i (
        .clk(clk), .rst(rst), .tick_us(tick_us), .en_i(slot_en),
        .fall_i(evt.fall), .line_i(line_i), .stat_o(slot)
    );

    assign id_bit   = ID[bit_idx];
    assign cmd_next = {slot.bit_v, cmd_sr[7:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            tri_ph  <= TRI_TRUE;
            cmd_sr  <= '0;
            cmd_cnt <= '0;
            bit_idx <= '0;
        end else if (evt.reset_done) begin
            state   <= ST_PRES;
            tri_ph  <= TRI_TRUE;
            cmd_cnt <= '0;
            bit_idx <= '0;
        end else if (evt.long_low) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_PRES: if (pres_done) state <= ST_CMD;
                ST_CMD: if (slot.done) begin
                    cmd_sr  <= cmd_next;
                    cmd_cnt <= cmd_cnt + 1'b1;
                    if (cmd_cnt == 3'd7) begin
                        bit_idx <= '0;
                        tri_ph  <= TRI_TRUE;
                        if (cmd_next == CMD_READ_ID)        state <= ST_ROM;
                        else if (cmd_next == CMD_SEARCH_ID) state <= ST_SRCH;
                        else                                state <= ST_MUTE;
                    end
                end
                ST_ROM: if (slot.done) begin
                    if (bit_idx == LAST) state <= ST_MUTE;
                    else bit_idx <= bit_idx + 1'b1;
                end
                ST_SRCH: if (slot.done) begin
                    unique case (tri_ph)
                        TRI_TRUE: tri_ph <= TRI_COMP;
                        TRI_COMP: tri_ph <= TRI_PICK;
                        default: begin
                            tri_ph <= TRI_TRUE;
                            if (slot.bit_v != id_bit || bit_idx == LAST) state <= ST_MUTE;
                            else bit_idx <= bit_idx + 1'b1;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        slot_drive = 1'b0;
        if (slot.hold) begin
            if (state == ST_ROM) slot_drive = ~id_bit;
            else if (state == ST_SRCH) begin
                if (tri_ph == TRI_TRUE)      slot_drive = ~id_bit;
                else if (tri_ph == TRI_COMP) slot_drive = id_bit;
            end
        end
    end

    assign drive_low_o = pres_drive | slot_drive;
    assign presence_o  = pres_drive;
    assign sending_o   = (state == ST_ROM);
    assign searching_o = (state == ST_SRCH);
    assign muted_o     = (state == ST_MUTE);

    // R3: presence only follows a recognised reset
    p_presence_needs_reset_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pres_drive) |-> state == ST_PRES);

    // R9: a silent responder never pulls the line
    p_silent_when_muted_r9: assert property (@(posedge clk) disable iff (rst)
        state == ST_MUTE |-> !drive_low_o);

    // R10: after an abort the line is left alone
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE |-> !drive_low_o);

    // R11: status flags never overlap
    p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({presence_o, sending_o, searching_o, muted_o}));

    // R5: the transfer index advances only when a slot closes
    p_index_on_slot_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROM && $past(state == ST_ROM) && $past(bit_idx) != bit_idx)
            |-> $past(slot.done));

endmodule

// File: tb/owid_responder_tb.sv
module owid_responder_tb_top;

    localparam time         CLK_PERIOD = 10ns;
    localparam logic [7:0]  FAM_B      = 8'h01;
    localparam logic [47:0] SER_B      = 48'h3C5A96E10F27;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_us = 1'b0;
    logic master_low = 1'b0;
    logic drive_low, presence, sending, searching, muted;
    logic line_w;
    int   checks = 0;
    int   errors = 0;
    logic [63:0] id_exp;
    bit   pres_seen;

    assign line_w = ~(master_low | drive_low);

    always #(CLK_PERIOD / 2) clk = ~clk;

    owid_responder #(.FAMILY_CODE(FAM_B), .SERIAL_NO(SER_B)) dut_i (
        .clk(clk), .rst(rst), .tick_us(tick_us), .line_i(line_w),
        .drive_low_o(drive_low), .presence_o(presence), .sending_o(sending),
        .searching_o(searching), .muted_o(muted)
    );

    initial forever begin
        @(negedge clk);
        tick_us = ~tick_us;
    end

    function automatic logic [7:0] bench_chk(input logic [63:0] d, input int n);
        logic [7:0] s;
        logic       fb;
        s = 8'h00;
        for (int i = 0; i < n; i++) begin
            fb = s[0] ^ d[i];
            s  = {fb, s[7:1]} ^ {4'b0000, fb, fb, 2'b00};
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic bus_reset(input int low_us, output int dly, output int wid);
        master_low = 1'b1;
        wait_us(low_us);
        master_low = 1'b0;
        dly = -1;
        wid = 0;
        pres_seen = 1'b0;
        for (int t = 1; t <= 300; t++) begin
            wait_us(1);
            if (presence) pres_seen = 1'b1;
            if (!line_w) begin
                if (dly < 0) dly = t;
                wid++;
            end
        end
    endtask

    task automatic write_bit_t(input bit b, input int low_us);
        master_low = 1'b1;
        wait_us(low_us);
        master_low = 1'b0;
        wait_us(80 - low_us);
    endtask

    task automatic write_bit(input bit b);
        write_bit_t(b, b ? 5 : 70);
    endtask

    task automatic write_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) write_bit(v[i]);
    endtask

    task automatic read_bit(output bit b);
        master_low = 1'b1;
        wait_us(3);
        master_low = 1'b0;
        wait_us(12);
        b = line_w;
        wait_us(65);
    endtask

    task automatic read_id(output logic [63:0] v);
        bit b;
        for (int i = 0; i < 64; i++) begin
            read_bit(b);
            v[i] = b;
        end
    endtask

    task automatic do_reset_ok(input string req);
        int dly, wid;
        bus_reset(500, dly, wid);
        chk(dly > 0, req, "presence after reset", dly, 1);
    endtask

    task automatic t_reset_state();
        chk({drive_low, presence, sending, searching, muted} == 5'b0, "R12",
            "outputs after rst", {drive_low, presence, sending, searching, muted}, 0);
    endtask

    task automatic t_short_low();
        int dly, wid;
        bus_reset(300, dly, wid);
        chk(dly < 0 && !pres_seen, "R3", "no presence after 300us low", wid, 0);
    endtask

    task automatic t_presence();
        int dly, wid;
        bus_reset(500, dly, wid);
        chk(dly > 0, "R1", "presence after 500us low", dly, 1);
        chk(dly >= 15 && dly <= 60, "R2", "presence delay us", dly, 30);
        chk(wid >= 60 && wid <= 240, "R2", "presence width us", wid, 120);
        chk(pres_seen, "R11", "presence_o during pulse", pres_seen, 1);
    endtask

    task automatic t_read_id();
        logic [63:0] got;
        do_reset_ok("R5");
        write_byte(8'h33);
        chk(sending, "R11", "sending_o after 33h", sending, 1);
        read_id(got);
        chk(got == id_exp, "R5", "identity bits", got, id_exp);
        chk(got[7:0] == 8'h01, "R6", "family byte", got[7:0], 8'h01);
        chk(bench_chk(got, 64) == 8'h00, "R6", "check residue", bench_chk(got, 64), 0);
        chk(!sending && muted, "R11", "flags after transfer", {sending, muted}, 2'b01);
    endtask

    task automatic t_sample_point();
        logic [63:0] got;
        logic [7:0]  c;
        do_reset_ok("R4");
        c = 8'h33;
        for (int i = 0; i < 8; i++) write_bit_t(c[i], c[i] ? 25 : 40);
        chk(sending, "R4", "33h with 25/40us lows decoded", sending, 1);
        read_id(got);
        chk(got == id_exp, "R4", "identity after edge-timed command", got, id_exp);
    endtask

    task automatic t_unsupported(input logic [7:0] cmd);
        bit b;
        int lows;
        do_reset_ok("R9");
        write_byte(cmd);
        chk(muted && !sending && !searching, "R9", "muted_o after other command",
            {muted, sending, searching}, 3'b100);
        lows = 0;
        for (int i = 0; i < 8; i++) begin
            read_bit(b);
            if (!b) lows++;
        end
        chk(lows == 0, "R9", "low read slots when silent", lows, 0);
    endtask

    task automatic t_search_full();
        bit a, c;
        int bad;
        do_reset_ok("R7");
        write_byte(8'hF0);
        chk(searching, "R11", "searching_o after F0h", searching, 1);
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            read_bit(a);
            read_bit(c);
            if (a != id_exp[i] || c != !id_exp[i]) bad++;
            write_bit(id_exp[i]);
        end
        chk(bad == 0, "R7", "search bit/complement pairs wrong", bad, 0);
        chk(!searching && muted, "R7", "flags after full pass", {searching, muted}, 2'b01);
    endtask

    task automatic t_search_drop();
        bit a, c;
        int lows, bad;
        do_reset_ok("R8");
        write_byte(8'hF0);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            read_bit(a);
            read_bit(c);
            if (a != id_exp[i] || c != !id_exp[i]) bad++;
            write_bit(id_exp[i]);
        end
        chk(bad == 0 && searching, "R8", "still searching after 5 matches", bad, 0);
        read_bit(a);
        read_bit(c);
        write_bit(!id_exp[5]);
        chk(muted && !searching, "R8", "drop-out flags", {muted, searching}, 2'b10);
        lows = 0;
        for (int i = 0; i < 6; i++) begin
            read_bit(a);
            if (!a) lows++;
        end
        chk(lows == 0, "R8", "low slots after drop-out", lows, 0);
    endtask

    task automatic t_abort();
        logic [63:0] got;
        bit b;
        int dly, wid;
        do_reset_ok("R10");
        write_byte(8'h33);
        for (int i = 0; i < 10; i++) read_bit(b);
        bus_reset(500, dly, wid);
        chk(dly >= 15 && dly <= 60 && !sending, "R10", "presence after mid-transfer reset",
            dly, 30);
        write_byte(8'h33);
        read_id(got);
        chk(got == id_exp, "R10", "fresh identity after abort", got, id_exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        id_exp[55:0]  = {SER_B, FAM_B};
        id_exp[63:56] = bench_chk({8'h00, SER_B, FAM_B}, 56);
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        wait_us(20);
        t_short_low();
        t_presence();
        t_read_id();
        t_sample_point();
        t_unsupported(8'h55);
        t_unsupported(8'hCC);
        t_search_full();
        t_search_drop();
        t_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule